// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Victim Selector

This block holds the replacement bookkeeping for an 8-way set-associative cache with 128 sets. For each set it keeps a 7-bit binary decision tree and an 8-bit mask of which ways hold a line. A lookup stage gives it a set index and gets back, with no clock in between, the way that a refill should overwrite.

While a set still has an empty way, the lowest-numbered empty way is chosen. Once all eight ways are occupied, the tree is walked instead. Every access to a way, whether a hit or a fill, rewrites that set's tree so that it points away from the way just used. A fill-commit input marks a way as occupied. A per-set invalidate empties the whole set and leaves its tree as it is.

Top module: `plru8_victim_sel`

## Requirements
- R1: `q_way` is a combinational function of `q_set` and the registered state. A change of `q_set` alone changes `q_way` without a clock edge.
- R2: If the selected set's valid mask is not all ones, `q_way` is the lowest-numbered way whose valid bit is 0.
- R3: If all eight valid bits are set, the tree bits t[6:0] choose the way. With t0=1, the way is in 4..7: t2=1 gives 7 if t6=1 and 6 if t6=0, and t2=0 gives 5 if t5=1 and 4 if t5=0. With t0=0, the way is in 0..3: t1=1 gives 3 if t4=1 and 2 if t4=0, and t1=0 gives 1 if t3=1 and 0 if t3=0.
- R4: An access to way w changes that set's tree to (t AND NOT M[w]) OR V[w]. For ways 0..7, M is 11,11,19,19,37,37,69,69 and V is 11,3,17,1,36,4,64,0 (decimal).
- R5: An access changes only the tree of the addressed set and never changes any valid bit.
- R6: A fill commit sets the valid bit of the addressed way in the addressed set. It does not change any tree.
- R7: An invalidate clears all eight valid bits of the addressed set and leaves its tree unchanged.
- R8: A synchronous reset clears every valid mask and every tree to zero, so every set then reports way 0.
- R9: An access and a fill commit issued to the same set in the same cycle both take effect.
- R10: An invalidate and a fill commit issued to the same set in the same cycle leave that set's valid mask at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_set | input | 7 | Set index for the victim query |
| q_way | output | 3 | Victim way for `q_set` |
| acc_en | input | 1 | Access strobe (hit or fill use) |
| acc_set | input | 7 | Set of the access |
| acc_way | input | 3 | Way of the access |
| fill_en | input | 1 | Fill-commit strobe |
| fill_set | input | 7 | Set being filled |
| fill_way | input | 3 | Way being filled |
| inv_en | input | 1 | Set-invalidate strobe |
| inv_set | input | 7 | Set to invalidate |

## Verification
A corrupted tree bit or valid bit shows at `q_way` as soon as that set is queried, in the cycle after the faulty write, because the query has no pipeline stage. A tree fault stays hidden while the set still has an empty way, so every access sequence is checked again after the set is full. Faults that cross sets or drop a write only show when the right set is queried, so the bench checks untouched neighbouring sets and same-cycle collisions explicitly.

// File: rtl/plru8_pkg.sv
package plru8_pkg;

    localparam int WAYS   = 8;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [TREE_W-1:0] tree_t;
    typedef logic [WAYS-1:0]   vmask_t;

    // Bits an access to a way forces, and the values forced into them
    typedef struct packed {
        tree_t touch;
        tree_t force_val;
    } tree_upd_t;

    // Root decides upper/lower half; level-1 node is 1 or 2; leaf is 3..6
    function automatic tree_upd_t upd_pattern(way_t w);
        tree_upd_t p;
        int unsigned mid;
        int unsigned leaf;
        mid  = w[2] ? 2 : 1;
        leaf = 3 + int'(w[2:1]);
        p.touch          = '0;
        p.force_val      = '0;
        p.touch[0]       = 1'b1;
        p.touch[mid]     = 1'b1;
        p.touch[leaf]    = 1'b1;
        p.force_val[0]    = ~w[2];
        p.force_val[mid]  = ~w[1];
        p.force_val[leaf] = ~w[0];
        return p;
    endfunction

    function automatic tree_t tree_apply(tree_t t, way_t w);
        tree_upd_t p;
        p = upd_pattern(w);
        return (t & ~p.touch) | p.force_val;
    endfunction

    function automatic way_t tree_pick(tree_t t);
        logic        hi;
        logic        md;
        int unsigned leaf;
        hi   = t[0];
        md   = hi ? t[2] : t[1];
        leaf = 3 + int'({hi, md});
        return {hi, md, t[leaf]};
    endfunction

endpackage

// File: rtl/plru8_tree_store.sv
module plru8_tree_store
    import plru8_pkg::*;
#(
    parameter int NUM_SETS = 128,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  way_t             upd_way,
    input  logic [SET_W-1:0] rd_set,
    output tree_t            rd_tree
);

    tree_t tree_q [NUM_SETS];
    tree_t upd_next;

    assign upd_next = tree_apply(tree_q[upd_set], upd_way);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                tree_q[s] <= '0;
            end
        end else if (upd_en) begin
            tree_q[upd_set] <= upd_next;
        end
    end

    assign rd_tree = tree_q[rd_set];

    // R4
    just_used_not_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && upd_en) |=> (tree_pick(tree_q[$past(upd_set)]) != $past(upd_way)));

endmodule

// File: rtl/plru8_valid_store.sv
module plru8_valid_store
    import plru8_pkg::*;
#(
    parameter int NUM_SETS = 128,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  way_t             fill_way,
    input  logic             inv_en,
    input  logic [SET_W-1:0] inv_set,
    input  logic [SET_W-1:0] rd_set,
    output vmask_t           rd_mask
);

    vmask_t vmask_q [NUM_SETS];
    logic   fill_blocked;

    assign fill_blocked = inv_en && (inv_set == fill_set);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                vmask_q[s] <= '0;
            end
        end else begin
            if (fill_en && !fill_blocked) begin
                vmask_q[fill_set][fill_way] <= 1'b1;
            end
            if (inv_en) begin
                vmask_q[inv_set] <= '0;
            end
        end
    end

    assign rd_mask = vmask_q[rd_set];

    // R7
    inv_clears_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && inv_en) |=> (vmask_q[$past(inv_set)] == '0));

    // R6
    fill_marks_way_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && fill_en && !(inv_en && inv_set == fill_set))
            |=> vmask_q[$past(fill_set)][$past(fill_way)]);

endmodule

// File: rtl/plru8_pick.sv
module plru8_pick
    import plru8_pkg::*;
(
    input  tree_t  tree,
    input  vmask_t vmask,
    output way_t   way
);

    // Priority chain: first_free[i] holds the lowest empty way among 0..i-1
    logic [WAYS:0] any_free;
    way_t          first_free [WAYS+1];

    assign any_free[0]   = 1'b0;
    assign first_free[0] = '0;

    for (genvar i = 0; i < WAYS; i++) begin : g_scan
        assign any_free[i+1]   = any_free[i] | ~vmask[i];
        assign first_free[i+1] = any_free[i] ? first_free[i] : way_t'(i);
    end

    assign way = any_free[WAYS] ? first_free[WAYS] : tree_pick(tree);

endmodule

// File: rtl/plru8_victim_sel.sv
module plru8_victim_sel
    import plru8_pkg::*;
#(
    parameter int NUM_SETS = 128,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] q_set,
    output logic [2:0]       q_way,
    input  logic             acc_en,
    input  logic [SET_W-1:0] acc_set,
    input  logic [2:0]       acc_way,
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [2:0]       fill_way,
    input  logic             inv_en,
    input  logic [SET_W-1:0] inv_set
);

    tree_t  q_tree;
    vmask_t q_vmask;
    way_t   pick_way;

    plru8_tree_store #(.NUM_SETS(NUM_SETS)) u_tree (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (acc_en),
        .upd_set (acc_set),
        .upd_way (acc_way),
        .rd_set  (q_set),
        .rd_tree (q_tree)
    );

    plru8_valid_store #(.NUM_SETS(NUM_SETS)) u_valid (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_en),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .inv_en   (inv_en),
        .inv_set  (inv_set),
        .rd_set   (q_set),
        .rd_mask  (q_vmask)
    );

    plru8_pick u_pick (
        .tree  (q_tree),
        .vmask (q_vmask),
        .way   (pick_way)
    );

    assign q_way = pick_way;

    // R2
    victim_is_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (q_vmask != '1) |-> !q_vmask[q_way]);

    // R8
    reset_gives_way0_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !rst) |-> (q_way == '0));

endmodule

// File: tb/plru8_victim_sel_tb.sv
module plru8_victim_sel_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] q_set = '0;
    logic [2:0] q_way;
    logic       acc_en = 1'b0, fill_en = 1'b0, inv_en = 1'b0;
    logic [6:0] acc_set = '0, fill_set = '0, inv_set = '0;
    logic [2:0] acc_way = '0, fill_way = '0;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    plru8_victim_sel u_dut (
        .clk(clk), .rst(rst), .q_set(q_set), .q_way(q_way),
        .acc_en(acc_en), .acc_set(acc_set), .acc_way(acc_way),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .inv_en(inv_en), .inv_set(inv_set)
    );

    // Reference model built from the requirements
    logic [6:0] m_tree  [128];
    logic [7:0] m_valid [128];
    int MSK [8] = '{11, 11, 19, 19, 37, 37, 69, 69};
    int VAL [8] = '{11, 3, 17, 1, 36, 4, 64, 0};

    int    q_exp [$];
    string q_tag [$];

    function automatic int exp_victim(int s);
        logic [7:0] v;
        logic [6:0] t;
        v = m_valid[s];
        t = m_tree[s];
        if (v != 8'hFF) begin
            for (int w = 0; w < 8; w++) if (!v[w]) return w;
        end
        if (t[0]) begin
            if (t[2]) return t[6] ? 7 : 6;
            else      return t[5] ? 5 : 4;
        end else begin
            if (t[1]) return t[4] ? 3 : 2;
            else      return t[3] ? 1 : 0;
        end
    endfunction

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            int    e;
            string tg;
            e  = q_exp.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (int'(q_way) != e) begin
                errors++;
                $display("FAIL %s set=%0d actual=%0d expected=%0d", tg, q_set, q_way, e);
            end
        end
    end

    task automatic step(input bit a_en, input int a_set, input int a_way,
                        input bit f_en, input int f_set, input int f_way,
                        input bit i_en, input int i_set,
                        input int chk_set, input string tag);
        acc_en = a_en;   acc_set = 7'(a_set);   acc_way = 3'(a_way);
        fill_en = f_en;  fill_set = 7'(f_set);  fill_way = 3'(f_way);
        inv_en = i_en;   inv_set = 7'(i_set);
        @(posedge clk);
        #1;
        acc_en = 1'b0; fill_en = 1'b0; inv_en = 1'b0;
        if (a_en) m_tree[a_set] = 7'((int'(m_tree[a_set]) & ~MSK[a_way]) | VAL[a_way]);
        if (f_en && !(i_en && i_set == f_set)) m_valid[f_set][f_way] = 1'b1;
        if (i_en) m_valid[i_set] = '0;
        q_set = 7'(chk_set);
        q_exp.push_back(exp_victim(chk_set));
        q_tag.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    // Immediate query without a clock edge
    task automatic peek(input int s, input string tag);
        int e;
        q_set = 7'(s);
        #1;
        e = exp_victim(s);
        checks++;
        if (int'(q_way) != e) begin
            errors++;
            $display("FAIL %s set=%0d actual=%0d expected=%0d", tag, s, q_way, e);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < 128; s++) begin
            m_tree[s] = '0;
            m_valid[s] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8: after reset every set reports way 0
        peek(0, "R8");
        peek(127, "R8");
        peek(5, "R8");

        // R6 and R2: fill set 3 in order, victim follows lowest empty way
        for (int w = 0; w < 8; w++) step(0, 0, 0, 1, 3, w, 0, 0, 3, "R6");
        // R3: full set with zero tree reports way 0
        peek(3, "R3");

        // R4 and R3: accesses walk the tree of a full set
        step(1, 3, 0, 0, 0, 0, 0, 0, 3, "R4");
        step(1, 3, 5, 0, 0, 0, 0, 0, 3, "R4");
        step(1, 3, 2, 0, 0, 0, 0, 0, 3, "R4");
        step(1, 3, 7, 0, 0, 0, 0, 0, 3, "R4");
        step(1, 3, 3, 0, 0, 0, 0, 0, 3, "R3");
        step(1, 3, 6, 0, 0, 0, 0, 0, 3, "R3");
        step(1, 3, 1, 0, 0, 0, 0, 0, 3, "R4");
        step(1, 3, 4, 0, 0, 0, 0, 0, 3, "R4");

        // R5: neighbours untouched, access sets no valid bit
        peek(4, "R5");
        step(1, 20, 0, 0, 0, 0, 0, 0, 20, "R5");
        step(1, 20, 3, 0, 0, 0, 0, 0, 3, "R5");

        // R2: out of order fills
        step(0, 0, 0, 1, 10, 0, 0, 0, 10, "R2");
        step(0, 0, 0, 1, 10, 1, 0, 0, 10, "R2");
        step(0, 0, 0, 1, 10, 3, 0, 0, 10, "R2");
        step(0, 0, 0, 1, 10, 2, 0, 0, 10, "R2");

        // R1: query change alone, with no clock edge
        peek(10, "R1");
        peek(3, "R1");
        peek(20, "R1");

        // R7: invalidate empties the set and keeps the tree
        step(1, 3, 2, 0, 0, 0, 0, 0, 3, "R4");
        step(0, 0, 0, 0, 0, 0, 1, 3, 3, "R7");
        for (int w = 7; w >= 0; w--) step(0, 0, 0, 1, 3, w, 0, 0, 3, "R7");

        // R9: access and fill to the same set in one cycle
        for (int w = 0; w < 7; w++) step(0, 0, 0, 1, 40, w, 0, 0, 40, "R6");
        step(1, 40, 0, 1, 40, 7, 0, 0, 40, "R9");

        // R10: invalidate beats fill on the same set; other set unaffected
        step(0, 0, 0, 1, 40, 0, 1, 40, 40, "R10");
        step(0, 0, 0, 1, 41, 0, 1, 40, 41, "R6");
        peek(40, "R10");

        // Mixed traffic over a few sets
        for (int n = 0; n < 300; n++) begin
            int r;
            r = int'($urandom_range(0, 1023));
            step(r[0], r[3:1], r[6:4], r[7], (r >> 2) & 7, (r >> 5) & 7,
                 (r[9:8] == 2'b11), (r >> 4) & 7, (r >> 1) & 7, "R4");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule